// File: doc/BRIEF.md
# Timestamped Event Sequence Player

This block plays back a small table of timed events once per machine cycle. Each table entry holds a timestamp, an 8-bit event code and a flag that marks it as injection-related. A cycle trigger starts playback. A free-running offset counter then counts event-clock ticks from zero. Each entry's code is sent out on the tick where the counter reaches the entry's effective timestamp. An entry with code 0x00 ends the cycle, and so does running past the last table slot. The table is played again from its start on every later trigger. With an event clock of about 125 MHz, one tick is about 8 ns.

A host loads entries into a shadow bank while the active bank plays. A commit strobe makes the shadow bank active at the next accepted trigger. A per-entry enable mask is also latched at that trigger, so individual device events can be switched on or off from shot to shot. A storage-ring bucket address is sampled at the trigger. A quarter of it, rounded down, is added to the timestamps of injection-flagged entries. The remainder is sent to a downstream gun-delay unit as a fine delay code in 2 ns steps.

Top module: `evseq_player`

## Requirements
- R1: After reset, evt_code_o is 0x00, fine_delay_o is 0, busy_o is 0 and overrun_o is 0.
- R2: A trigger sampled while busy_o is 0 starts playback, and busy_o is 1 after that edge. An enabled entry whose effective timestamp is t puts its code on evt_code_o for one cycle, visible after the (t+1)-th clock edge following the edge that sampled the trigger. evt_code_o is 0x00 in every cycle with no event.
- R3: Entries are meant to be in ascending timestamp order. An entry whose effective timestamp is not later than the slot of the entry before it is emitted in the slot right after that entry.
- R4: An entry with code 0x00 ends playback, and so does reaching index DEPTH. In both cases busy_o falls at the edge after the first slot that follows the last emission, and no later entry is played.
- R5: mask_i bit i gates entry i: 1 emits the entry and 0 outputs 0x00 in its slot. A suppressed entry still uses its slot. A mask written with mask_wr_i takes effect only at the next accepted trigger.
- R6: Entries whose injection flag is 1 have floor(b/4) added to their timestamp, where b is the bucket address sampled with the accepted trigger. For example, b = 132 adds 33 ticks. Entries with the flag at 0 are not shifted.
- R7: fine_delay_o is loaded at each accepted trigger with b mod 4, in units of 2 ns, and holds that value until the next accepted trigger. For example, 133 gives 1 and 134 gives 2.
- R8: Bucket addresses above 827 are treated as 827 (offset 206, fine code 3).
- R9: Host writes go only to the shadow bank and never change the table being played. After commit_i, the next accepted trigger makes the shadow bank active. Triggers without a prior commit replay the same active table.
- R10: A trigger that arrives while busy_o is 1 is ignored and does not disturb the running sequence. It sets overrun_o, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Cycle trigger, one-cycle pulse |
| wr_en_i | input | 1 | Write one entry into the shadow bank |
| wr_addr_i | input | 4 | Entry index to write |
| wr_ts_i | input | 16 | Entry timestamp in ticks |
| wr_code_i | input | 8 | Entry event code, 0x00 marks the end |
| wr_inj_i | input | 1 | Entry is injection-related |
| mask_wr_i | input | 1 | Load the pending enable mask |
| mask_i | input | 16 | Per-entry enable bits, bit i for entry i |
| commit_i | input | 1 | Arm a bank swap at the next accepted trigger |
| bucket_i | input | 10 | Storage-ring bucket address |
| evt_code_o | output | 8 | Emitted event code, 0x00 when idle |
| fine_delay_o | output | 2 | Gun fine delay in 2 ns steps |
| busy_o | output | 1 | Playback in progress |
| overrun_o | output | 1 | Sticky: a trigger arrived during playback |

## Verification
The hardest cases to reach are a trigger that lands in the middle of a running sequence and a commit whose bank swap must wait for a trigger. The bench raises trig_i a fixed number of ticks into a non-empty playback. It then checks every following slot against the sequence predicted from the table latched at the start. Separately, it writes a second table into the shadow bank without committing and checks that a further trigger still replays the first table. After the commit, the next trigger must play the second table. Random tables add equal and decreasing timestamps, mixed injection flags and masks, and bucket addresses across 0 to 827. Directed shots cover addresses 132, 133, 134 and the clamp above 827.

// File: rtl/evseq_pkg.sv
package evseq_pkg;
    localparam int TS_W    = 16;
    localparam int CODE_W  = 8;
    localparam int BKT_W   = 10;
    localparam int BKT_MAX = 827;
    localparam int DEPTH   = 16;
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int CRS_W   = BKT_W - 2;
    localparam int CNT_W   = TS_W + 1;

    typedef struct packed {
        logic [TS_W-1:0]   ts;
        logic [CODE_W-1:0] code;
        logic              inj;
    } seq_entry_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_PLAY = 1'b1} play_state_e;

    function automatic logic [BKT_W-1:0] clamp_bucket(input logic [BKT_W-1:0] b);
        return (b > BKT_W'(BKT_MAX)) ? BKT_W'(BKT_MAX) : b;
    endfunction

    function automatic logic [CRS_W-1:0] coarse_of(input logic [BKT_W-1:0] b);
        return b[BKT_W-1:2];
    endfunction

    function automatic logic [1:0] fine_of(input logic [BKT_W-1:0] b);
        return b[1:0];
    endfunction
endpackage

// File: rtl/evseq_table_banks.sv
module evseq_table_banks
    import evseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDX_W-1:0] wr_addr,
    input  seq_entry_t       wr_entry,
    input  logic             rd_bank,
    input  logic [IDX_W-1:0] rd_addr,
    output seq_entry_t       rd_entry
);
    seq_entry_t rd_pick [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        seq_entry_t mem [DEPTH];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en && (wr_bank == 1'(b))) begin
                mem[wr_addr] <= wr_entry;
            end
        end
        assign rd_pick[b] = mem[rd_addr];
    end

    assign rd_entry = rd_pick[rd_bank];
endmodule

// File: rtl/evseq_bucket_offset.sv
module evseq_bucket_offset
    import evseq_pkg::*;
(
    input  logic [BKT_W-1:0] bucket,
    output logic [CRS_W-1:0] coarse,
    output logic [1:0]       fine
);
    logic [BKT_W-1:0] bkt_c;

    always_comb begin
        bkt_c  = clamp_bucket(bucket);
        coarse = coarse_of(bkt_c);
        fine   = fine_of(bkt_c);
    end
endmodule

// File: rtl/evseq_play_ctrl.sv
module evseq_play_ctrl
    import evseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic              mask_wr,
    input  logic [DEPTH-1:0]  mask_in,
    input  logic              commit,
    input  logic [CRS_W-1:0]  coarse_in,
    input  logic [1:0]        fine_in,
    input  seq_entry_t        cur_entry,
    output logic [IDX_W-1:0]  rd_addr,
    output logic              act_bank,
    output logic [CODE_W-1:0] evt_code,
    output logic [1:0]        fine_q,
    output logic              busy,
    output logic              overrun
);
    play_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W:0]    idx;
    logic [DEPTH-1:0]  mask_pend, mask_live;
    logic [CRS_W-1:0]  coarse_q;
    logic              swap_pend;
    logic [CNT_W-1:0]  eff_ts;
    logic              at_end, due;

    always_comb begin
        eff_ts = {1'b0, cur_entry.ts} + (cur_entry.inj ? CNT_W'(coarse_q) : '0);
        at_end = idx[IDX_W] || (cur_entry.code == '0);
        due    = (eff_ts <= cnt);
    end

    assign rd_addr = idx[IDX_W-1:0];
    assign busy    = (state == ST_PLAY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            idx       <= '0;
            mask_pend <= '0;
            mask_live <= '0;
            coarse_q  <= '0;
            fine_q    <= '0;
            swap_pend <= 1'b0;
            act_bank  <= 1'b0;
            evt_code  <= '0;
            overrun   <= 1'b0;
        end else begin
            evt_code <= '0;
            if (mask_wr) mask_pend <= mask_in;
            if (commit)  swap_pend <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (trig) begin
                        state     <= ST_PLAY;
                        cnt       <= '0;
                        idx       <= '0;
                        mask_live <= mask_pend;
                        coarse_q  <= coarse_in;
                        fine_q    <= fine_in;
                        if (swap_pend) begin
                            act_bank  <= ~act_bank;
                            swap_pend <= commit;
                        end
                    end
                end
                ST_PLAY: begin
                    if (trig) overrun <= 1'b1;
                    if (cnt != '1) cnt <= cnt + 1'b1;
                    if (at_end) begin
                        state <= ST_IDLE;
                    end else if (due) begin
                        evt_code <= mask_live[rd_addr] ? cur_entry.code : '0;
                        idx      <= idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/evseq_player.sv
module evseq_player
    import evseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_addr_i,
    input  logic [TS_W-1:0]   wr_ts_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic              wr_inj_i,
    input  logic              mask_wr_i,
    input  logic [DEPTH-1:0]  mask_i,
    input  logic              commit_i,
    input  logic [BKT_W-1:0]  bucket_i,
    output logic [CODE_W-1:0] evt_code_o,
    output logic [1:0]        fine_delay_o,
    output logic              busy_o,
    output logic              overrun_o
);
    seq_entry_t       wr_entry, cur_entry;
    logic [IDX_W-1:0] rd_addr;
    logic             act_bank;
    logic [CRS_W-1:0] coarse;
    logic [1:0]       fine;

    assign wr_entry = '{ts: wr_ts_i, code: wr_code_i, inj: wr_inj_i};

    evseq_table_banks u_tbl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en_i),
        .wr_bank  (~act_bank),
        .wr_addr  (wr_addr_i),
        .wr_entry (wr_entry),
        .rd_bank  (act_bank),
        .rd_addr  (rd_addr),
        .rd_entry (cur_entry)
    );

    evseq_bucket_offset u_bkt (
        .bucket (bucket_i),
        .coarse (coarse),
        .fine   (fine)
    );

    evseq_play_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig_i),
        .mask_wr   (mask_wr_i),
        .mask_in   (mask_i),
        .commit    (commit_i),
        .coarse_in (coarse),
        .fine_in   (fine),
        .cur_entry (cur_entry),
        .rd_addr   (rd_addr),
        .act_bank  (act_bank),
        .evt_code  (evt_code_o),
        .fine_q    (fine_delay_o),
        .busy      (busy_o),
        .overrun   (overrun_o)
    );
endmodule

// File: rtl/evseq_player_chk.sv
module evseq_player_chk
    import evseq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              trig_i,
    input logic [CODE_W-1:0] evt_code_o,
    input logic [1:0]        fine_delay_o,
    input logic              busy_o,
    input logic              overrun_o
);
    assert_code_only_in_play_R2: assert property (@(posedge clk) disable iff (rst)
        (evt_code_o != '0) |-> $past(busy_o));

    assert_idle_trig_starts_R2: assert property (@(posedge clk) disable iff (rst)
        (trig_i && !busy_o) |=> busy_o);

    assert_fine_held_R7: assert property (@(posedge clk) disable iff (rst)
        !(trig_i && !busy_o) |=> $stable(fine_delay_o));

    assert_overrun_set_R10: assert property (@(posedge clk) disable iff (rst)
        (trig_i && busy_o) |=> overrun_o);

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);
endmodule

bind evseq_player evseq_player_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .trig_i       (trig_i),
    .evt_code_o   (evt_code_o),
    .fine_delay_o (fine_delay_o),
    .busy_o       (busy_o),
    .overrun_o    (overrun_o)
);

// File: tb/evseq_player_tb_top.sv
module evseq_player_tb_top;
    import evseq_pkg::*;

    localparam int MAXL = 700;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              trig_i = 1'b0, wr_en_i = 1'b0, wr_inj_i = 1'b0;
    logic [IDX_W-1:0]  wr_addr_i = '0;
    logic [TS_W-1:0]   wr_ts_i = '0;
    logic [CODE_W-1:0] wr_code_i = '0;
    logic              mask_wr_i = 1'b0, commit_i = 1'b0;
    logic [DEPTH-1:0]  mask_i = '0;
    logic [BKT_W-1:0]  bucket_i = '0;
    logic [CODE_W-1:0] evt_code_o;
    logic [1:0]        fine_delay_o;
    logic              busy_o, overrun_o;

    int n_chk = 0, n_fail = 0;

    int m_ts   [2][DEPTH];
    int m_code [2][DEPTH];
    int m_inj  [2][DEPTH];
    int m_act = 0, m_pend = 0, m_ovr = 0;
    logic [DEPTH-1:0] m_mask_pend = '0, m_mask_live = '0;
    int exp_code [MAXL];
    int stop_e, exp_fine;

    always #4 clk = ~clk;

    evseq_player dut_i (.*);

    task automatic chk(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic host_write(input int a, input int ts, input int code, input int inj);
        @(posedge clk); #2;
        wr_en_i = 1'b1; wr_addr_i = IDX_W'(a); wr_ts_i = TS_W'(ts);
        wr_code_i = CODE_W'(code); wr_inj_i = inj[0];
        m_ts[1-m_act][a] = ts; m_code[1-m_act][a] = code; m_inj[1-m_act][a] = inj;
        @(posedge clk); #2;
        wr_en_i = 1'b0;
    endtask

    task automatic set_mask(input logic [DEPTH-1:0] m);
        @(posedge clk); #2; mask_wr_i = 1'b1; mask_i = m; m_mask_pend = m;
        @(posedge clk); #2; mask_wr_i = 1'b0;
    endtask

    task automatic commit();
        @(posedge clk); #2; commit_i = 1'b1; m_pend = 1;
        @(posedge clk); #2; commit_i = 1'b0;
    endtask

    function automatic void build_exp(input int b);
        int bc, crs, prev, eff, f;
        bc = (b > BKT_MAX) ? BKT_MAX : b;
        crs = bc / 4;
        exp_fine = bc % 4;
        for (int k = 0; k < MAXL; k++) exp_code[k] = 0;
        prev = -1;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_code[m_act][i] == 0) break;
            eff = m_ts[m_act][i] + (m_inj[m_act][i] != 0 ? crs : 0);
            f = (eff > prev + 1) ? eff : prev + 1;
            exp_code[f + 1] = m_mask_live[i] ? m_code[m_act][i] : 0;
            prev = f;
        end
        stop_e = prev + 2;
    endfunction

    task automatic run_shot(input string tag, input int b, input int ovr_at);
        @(posedge clk); #2;
        bucket_i = BKT_W'(b); trig_i = 1'b1;
        if (m_pend != 0) begin m_act = 1 - m_act; m_pend = 0; end
        m_mask_live = m_mask_pend;
        build_exp(b);
        @(posedge clk); #2;
        chk({tag, " R2 busy after trigger"}, int'(busy_o), 1);
        chk({tag, " R7 fine delay"}, int'(fine_delay_o), exp_fine);
        trig_i = (ovr_at == 1);
        if (ovr_at > 0) m_ovr = 1;
        for (int k = 1; k <= stop_e + 2; k++) begin
            @(posedge clk); #2;
            chk({tag, " R2 event code"}, int'(evt_code_o), exp_code[k]);
            chk({tag, " R4 busy"}, int'(busy_o), (k < stop_e) ? 1 : 0);
            trig_i = (k + 1 == ovr_at);
        end
        trig_i = 1'b0;
        chk({tag, " R7 fine held"}, int'(fine_delay_o), exp_fine);
        chk({tag, " R10 overrun flag"}, int'(overrun_o), m_ovr);
    endtask

    initial begin
        int seed, n, ts;
        seed = $urandom(32'd5150);
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < DEPTH; i++) begin
                m_ts[b][i] = 0; m_code[b][i] = 0; m_inj[b][i] = 0;
            end
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        chk("R1 code", int'(evt_code_o), 0);
        chk("R1 fine", int'(fine_delay_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 overrun", int'(overrun_o), 0);

        // Table A: plain, injection, equal stamp (R3), decreasing stamp (R3), null
        host_write(0, 5, 8'h11, 0);
        host_write(1, 10, 8'h22, 1);
        host_write(2, 10, 8'h33, 0);
        host_write(3, 4, 8'h44, 0);
        host_write(4, 60, 8'h55, 1);
        host_write(5, 0, 0, 0);
        set_mask(16'hFFFF);
        commit();
        run_shot("R6 b132", 132, 0);
        run_shot("R6 R7 b133", 133, 0);
        run_shot("R7 b134", 134, 0);
        run_shot("R8 clamp", 1000, 0);
        run_shot("R3 b0", 0, 0);
        // R5: mask off entries 1 and 3; takes effect only at the next trigger
        set_mask(16'hFFF5);
        run_shot("R5 masked", 4, 0);
        // R9: write table B into shadow without commit, replay must stay table A
        host_write(0, 2, 8'hA1, 0);
        host_write(1, 3, 8'hA2, 1);
        host_write(2, 0, 0, 0);
        set_mask(16'hFFFF);
        run_shot("R9 no commit", 8, 0);
        commit();
        run_shot("R9 swapped", 8, 0);
        run_shot("R9 replay", 9, 0);
        // R4: full table with no null entry
        for (int i = 0; i < DEPTH; i++) host_write(i, 3 * i, i + 1, i % 2);
        commit();
        run_shot("R4 full table", 20, 0);
        // Random tables
        for (int r = 0; r < 20; r++) begin
            n = (r % 5 == 0) ? DEPTH : int'($urandom_range(0, DEPTH - 1));
            ts = int'($urandom_range(0, 30));
            for (int i = 0; i < DEPTH; i++) begin
                if (i < n) begin
                    host_write(i, ts, int'($urandom_range(1, 255)), int'($urandom_range(0, 1)));
                    ts = ts + int'($urandom_range(0, 12)) - (($urandom_range(0, 7) == 0) ? 4 : 0);
                    if (ts < 0) ts = 0;
                end else host_write(i, 0, 0, 0);
            end
            set_mask(DEPTH'($urandom));
            commit();
            run_shot("R2 R3 random", int'($urandom_range(0, 827)), 0);
        end
        // R10: trigger during playback is ignored; flag sticks
        host_write(0, 6, 8'h5A, 0);
        host_write(1, 9, 8'h5B, 1);
        host_write(2, 0, 0, 0);
        set_mask(16'hFFFF);
        commit();
        run_shot("R10 overrun", 40, 2);
        run_shot("R10 sticky", 41, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule